// File: doc/BRIEF.md
# Clear Channel Assessment Controller

This block tells a CSMA transmitter whether the channel is busy. It combines three measures. The first is an energy test, which compares a received signal strength value against a programmable threshold. The second is a carrier-sense flag that rises whenever the gain-control loop reports that it has lost lock. The third is a carrier-sense flag that reflects a timed correlation check. That check counts only when the gain loop stayed locked across the dwell and a correlation peak above threshold arrived in that dwell. A small acquisition state machine moves to tracking once the correlation evidence is strong enough. Tracking holds the busy indication until the receive window closes.

A dwell counter paces the correlation check. It runs in clock cycles, scaled by a cycles-per-microsecond parameter, and restarts whenever receive is re-enabled. The check is taken at one fixed cycle inside the window from 8 µs to 9 µs of each 10 µs dwell. A 3-bit mode input selects which measures drive the busy output. One setting forces the output idle so that a transmitter can ignore the channel. A dropped receive-enable or an end-of-packet pulse clears all state.

Top module: `cca_top`

## Requirements
- R1: The energy measure is true when `rssiLevel >= rssiThresh` (unsigned). With `ccaMode` = 1 the busy output follows it, two clock edges after the level is presented.
- R2: `ccaMode` values 0, 6 and 7 force `ccaBusy` low one edge later, whatever the channel conditions.
- R3: While receive is enabled, any cycle with `agcLocked` low sets the gain-loss sense flag one edge later. With `ccaMode` = 2, `ccaBusy` reports this flag or tracking.
- R4: The gain-loss sense flag stays set until a valid correlation check finds no peak, and then it clears. A check taken in a dwell where lock was lost does not clear it.
- R5: A dwell lasts `10*CLK_PER_US` cycles and begins on the first enabled cycle after a restart. The check is taken at dwell cycle `8*CLK_PER_US + SAMPLE_FRAC`. It is valid only if `agcLocked` was high on every cycle of that dwell up to and including the check cycle. A peak is counted if `corrHit` pulsed in that dwell at or before the check cycle.
- R6: A valid check that finds a peak while the gain-loss flag is set raises `tracking` one edge later. Tracking then holds until a restart.
- R7: When the gain-loss flag is clear, two consecutive valid checks that both find a peak are needed to enter tracking. A valid check without a peak breaks the pair.
- R8: Reset, a low `rxEnable` or a high `endOfPacket` clears `tracking`, both sense flags, the pair state and the dwell counter. `ccaBusy` is then low on the next edge.
- R9: `ccaMode` 3 reports the correlation flag or tracking. Mode 4 reports energy OR any carrier sense. Mode 5 reports energy AND any carrier sense. Any carrier sense means the gain-loss flag, the correlation flag or tracking.
- R10: The correlation flag holds the result of the most recent valid check and is unchanged by invalid checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receive window open |
| endOfPacket | input | 1 | Single-cycle end-of-packet strobe |
| agcLocked | input | 1 | Gain-control loop lock status |
| corrHit | input | 1 | Correlation peak above threshold pulse |
| rssiLevel | input | RSSI_W | Received signal strength |
| rssiThresh | input | RSSI_W | Energy-detect threshold |
| ccaMode | input | 3 | Measure selection |
| ccaBusy | output | 1 | Channel busy indication |
| tracking | output | 1 | Acquisition has advanced to tracking |

## Verification
The bench keeps a behavioural model with its own dwell position and flags, and compares both outputs against it at every falling edge. Energy changes and gain loss reach `ccaBusy` two edges after the inputs are seen. A correlation check raises `tracking` on the edge after the check cycle, and `ccaBusy` follows one edge later. A restart empties `ccaBusy` and `tracking` after one edge. Directed scenarios place `corrHit` pulses and lock drops at known dwell positions by counting cycles from a restart. The point checks on `tracking` and `ccaBusy` are sampled several cycles past the check cycle, so no check depends on the exact edge.

// File: rtl/cca_pkg.sv
package cca_pkg;

  typedef enum logic [2:0] {
    MODE_OFF       = 3'd0,
    MODE_ENERGY    = 3'd1,
    MODE_GAINLOSS  = 3'd2,
    MODE_CORR      = 3'd3,
    MODE_EN_OR_CS  = 3'd4,
    MODE_EN_AND_CS = 3'd5,
    MODE_OFF_A     = 3'd6,
    MODE_OFF_B     = 3'd7
  } ccaMode_e;

  // control -> datapath
  typedef struct packed {
    logic restart;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic evalNow;     // dwell at its check cycle
    logic lockOk;      // lock held for whole dwell so far, incl. this cycle
    logic corrOk;      // peak seen in this dwell up to this cycle
    logic energyHigh;  // registered energy comparison
  } dwellInfo_t;

endpackage

// File: rtl/cca_dwell_path.sv
module cca_dwell_path
  import cca_pkg::*;
#(
  parameter int CLK_PER_US  = 4,
  parameter int DWELL_US    = 10,
  parameter int SAMPLE_US   = 8,
  parameter int SAMPLE_FRAC = 2,
  parameter int RSSI_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              agcLocked,
  input  logic              corrHit,
  input  logic [RSSI_W-1:0] rssiLevel,
  input  logic [RSSI_W-1:0] rssiThresh,
  output dwellInfo_t        info
);

  localparam int DWELL_CYC  = DWELL_US * CLK_PER_US;
  localparam int SAMPLE_CYC = SAMPLE_US * CLK_PER_US + SAMPLE_FRAC;
  localparam int CNT_W      = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;

  logic [CNT_W-1:0] dwellCnt;
  logic             lockRun;
  logic             corrSeen;
  logic             energyReg;
  logic             dwellStart;
  logic             dwellLast;

  assign dwellStart = (dwellCnt == '0);
  assign dwellLast  = (dwellCnt == CNT_W'(DWELL_CYC - 1));

  // dwell position counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dwellCnt <= '0;
    end else if (strobe.restart) begin
      dwellCnt <= '0;
    end else if (dwellLast) begin
      dwellCnt <= '0;
    end else begin
      dwellCnt <= dwellCnt + 1'b1;
    end
  end

  // lock-held and peak-seen accumulators, reopened at each dwell start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockRun  <= 1'b0;
      corrSeen <= 1'b0;
    end else if (strobe.restart) begin
      lockRun  <= 1'b0;
      corrSeen <= 1'b0;
    end else if (dwellStart) begin
      lockRun  <= agcLocked;
      corrSeen <= corrHit;
    end else begin
      lockRun  <= lockRun & agcLocked;
      corrSeen <= corrSeen | corrHit;
    end
  end

  // energy comparison register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      energyReg <= 1'b0;
    end else if (strobe.restart) begin
      energyReg <= 1'b0;
    end else begin
      energyReg <= (rssiLevel >= rssiThresh);
    end
  end

  always_comb begin
    info.evalNow    = !strobe.restart && (dwellCnt == CNT_W'(SAMPLE_CYC));
    info.lockOk     = lockRun & agcLocked;
    info.corrOk     = corrSeen | corrHit;
    info.energyHigh = energyReg;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    dwellCnt < CNT_W'(DWELL_CYC)); // R5
  AST_DWELL_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && dwellLast) |=> (dwellCnt == '0)); // R5
  AST_EVAL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    info.evalNow |=> !info.evalNow); // R5
  AST_RESTART_CNT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (dwellCnt == '0 && !energyReg)); // R8

endmodule

// File: rtl/cca_control.sv
module cca_control
  import cca_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       endOfPacket,
  input  logic       agcLocked,
  input  logic [2:0] ccaMode,
  input  dwellInfo_t info,
  output ctlStrobe_t strobe,
  output logic       ccaBusy,
  output logic       tracking
);

  logic     gainLoss;   // carrier sense from gain-loop unlock
  logic     corrSense;  // carrier sense from last valid check
  logic     pairWait;   // one valid hit seen without gain loss
  logic     validEval;
  logic     advance;
  logic     anySense;
  logic     busyNext;
  ccaMode_e modeSel;

  assign strobe.restart = !rxEnable || endOfPacket;
  assign validEval      = info.evalNow && info.lockOk;
  assign advance        = validEval && info.corrOk && (gainLoss || pairWait);
  assign anySense       = gainLoss | corrSense | tracking;
  assign modeSel        = ccaMode_e'(ccaMode);

  always_comb begin
    unique case (modeSel)
      MODE_ENERGY:    busyNext = info.energyHigh;
      MODE_GAINLOSS:  busyNext = gainLoss | tracking;
      MODE_CORR:      busyNext = corrSense | tracking;
      MODE_EN_OR_CS:  busyNext = info.energyHigh | anySense;
      MODE_EN_AND_CS: busyNext = info.energyHigh & anySense;
      default:        busyNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainLoss  <= 1'b0;
      corrSense <= 1'b0;
      pairWait  <= 1'b0;
      tracking  <= 1'b0;
      ccaBusy   <= 1'b0;
    end else if (strobe.restart) begin
      gainLoss  <= 1'b0;
      corrSense <= 1'b0;
      pairWait  <= 1'b0;
      tracking  <= 1'b0;
      ccaBusy   <= 1'b0;
    end else begin
      ccaBusy <= busyNext;

      if (!agcLocked) begin
        gainLoss <= 1'b1;
      end else if (validEval && (!info.corrOk || gainLoss)) begin
        gainLoss <= 1'b0;
      end

      if (validEval) begin
        corrSense <= info.corrOk;
      end

      if (advance) begin
        tracking <= 1'b1;
      end

      if (tracking || advance) begin
        pairWait <= 1'b0;
      end else if (validEval) begin
        pairWait <= info.corrOk && !gainLoss;
      end
    end
  end

  AST_GAIN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && !agcLocked) |=> gainLoss); // R3
  AST_GAIN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gainLoss) |-> $past(strobe.restart || info.evalNow)); // R4
  AST_TRACK_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tracking) |-> $past(info.evalNow && info.corrOk)); // R6
  AST_TRACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (tracking && !strobe.restart) |=> tracking); // R6
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ccaMode == 3'd0 || ccaMode == 3'd6 || ccaMode == 3'd7) |=> !ccaBusy); // R2
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (!tracking && !ccaBusy && !gainLoss && !corrSense)); // R8
  AST_CORR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && !info.evalNow) |=> $stable(corrSense)); // R10

endmodule

// File: rtl/cca_top.sv
module cca_top
  import cca_pkg::*;
#(
  parameter int CLK_PER_US  = 4,
  parameter int DWELL_US    = 10,
  parameter int SAMPLE_US   = 8,
  parameter int SAMPLE_FRAC = 2,
  parameter int RSSI_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              endOfPacket,
  input  logic              agcLocked,
  input  logic              corrHit,
  input  logic [RSSI_W-1:0] rssiLevel,
  input  logic [RSSI_W-1:0] rssiThresh,
  input  logic [2:0]        ccaMode,
  output logic              ccaBusy,
  output logic              tracking
);

  ctlStrobe_t strobe;
  dwellInfo_t info;

  cca_dwell_path #(
    .CLK_PER_US (CLK_PER_US),
    .DWELL_US   (DWELL_US),
    .SAMPLE_US  (SAMPLE_US),
    .SAMPLE_FRAC(SAMPLE_FRAC),
    .RSSI_W     (RSSI_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .agcLocked (agcLocked),
    .corrHit   (corrHit),
    .rssiLevel (rssiLevel),
    .rssiThresh(rssiThresh),
    .info      (info)
  );

  cca_control uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .rxEnable   (rxEnable),
    .endOfPacket(endOfPacket),
    .agcLocked  (agcLocked),
    .ccaMode    (ccaMode),
    .info       (info),
    .strobe     (strobe),
    .ccaBusy    (ccaBusy),
    .tracking   (tracking)
  );

endmodule

// File: tb/tb_cca_top.sv
module tb_cca_top;

  localparam int CPU = 4;
  localparam int DW  = 10 * CPU;
  localparam int SP  = 8 * CPU + 2;
  localparam int RW  = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          rxEnable = 1'b0;
  logic          endOfPacket = 1'b0;
  logic          agcLocked = 1'b1;
  logic          corrHit = 1'b0;
  logic [RW-1:0] rssiLevel = '0;
  logic [RW-1:0] rssiThresh = 8'd100;
  logic [2:0]    ccaMode = 3'd0;
  logic          ccaBusy;
  logic          tracking;

  cca_top #(.CLK_PER_US(CPU), .SAMPLE_FRAC(2), .RSSI_W(RW)) dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .endOfPacket(endOfPacket),
    .agcLocked(agcLocked), .corrHit(corrHit), .rssiLevel(rssiLevel),
    .rssiThresh(rssiThresh), .ccaMode(ccaMode), .ccaBusy(ccaBusy),
    .tracking(tracking)
  );

  int    total = 0;
  int    bad = 0;
  string curReq = "R8";
  bit    fin = 0;

  // behavioural reference
  int mPos;
  bit mLock, mCorr, mEd, mGl, mCs, mPair, mTrk, mBusy;

  function automatic bit mix(int mode, bit ed, bit gl, bit cs, bit trk);
    bit any;
    any = gl || cs || trk;
    case (mode)
      1: return ed;
      2: return gl || trk;
      3: return cs || trk;
      4: return ed || any;
      5: return ed && any;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin : refModel
    bit ok, hit, newGl, newCs, newPair, newTrk, adv;
    if (!rstN) begin
      mPos = 0; mLock = 0; mCorr = 0; mEd = 0;
      mGl = 0; mCs = 0; mPair = 0; mTrk = 0; mBusy = 0;
    end else if (!rxEnable || endOfPacket) begin
      mPos = 0; mLock = 0; mCorr = 0; mEd = 0;
      mGl = 0; mCs = 0; mPair = 0; mTrk = 0; mBusy = 0;
    end else begin
      ok  = (mPos == SP) && mLock && agcLocked;
      hit = mCorr || corrHit;
      adv = ok && hit && (mGl || mPair);
      newGl = mGl; newCs = mCs; newPair = mPair; newTrk = mTrk;
      if (!agcLocked) newGl = 1;
      else if (ok && (!hit || mGl)) newGl = 0;
      if (ok) newCs = hit;
      if (adv) newTrk = 1;
      if (mTrk || adv) newPair = 0;
      else if (ok) newPair = hit && !mGl;
      mBusy = mix(int'(ccaMode), mEd, mGl, mCs, mTrk);
      mGl = newGl; mCs = newCs; mPair = newPair; mTrk = newTrk;
      mLock = (mPos == 0) ? agcLocked : (mLock && agcLocked);
      mCorr = (mPos == 0) ? corrHit : (mCorr || corrHit);
      mPos  = (mPos == DW - 1) ? 0 : mPos + 1;
      mEd   = (rssiLevel >= rssiThresh);
    end
  end

  task automatic check(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !fin) begin
      check(ccaBusy, mBusy, "ccaBusy vs model");
      check(tracking, mTrk, "tracking vs model");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restartRx();
    rxEnable = 1'b0;
    cyc(1);
    rxEnable = 1'b1;
  endtask

  task automatic pulseCorr();
    corrHit = 1'b1;
    cyc(1);
    corrHit = 1'b0;
  endtask

  initial begin : stim
    // reset state, R8
    cyc(3);
    check(ccaBusy, 1'b0, "reset busy");
    check(tracking, 1'b0, "reset tracking");
    rstN = 1'b1;

    // R2: forced idle mode with every measure active
    curReq = "R2";
    ccaMode = 3'd0; rxEnable = 1'b1; agcLocked = 1'b0; rssiLevel = 8'd250;
    cyc(50);
    check(ccaBusy, 1'b0, "R2 mode 0 idle");
    ccaMode = 3'd7; cyc(5);
    check(ccaBusy, 1'b0, "R2 mode 7 idle");

    // R1: energy threshold boundary
    curReq = "R1";
    agcLocked = 1'b1; ccaMode = 3'd1; restartRx();
    rssiLevel = 8'd99; cyc(4);
    check(ccaBusy, 1'b0, "R1 below threshold");
    rssiLevel = 8'd100; cyc(2);
    check(ccaBusy, 1'b1, "R1 at threshold");
    rssiLevel = 8'd200; cyc(3);
    check(ccaBusy, 1'b1, "R1 above threshold");
    rssiLevel = 8'd0; cyc(3);

    // R3 and R4: gain loss, held through invalid check, cleared by empty valid check
    curReq = "R3";
    ccaMode = 3'd2; agcLocked = 1'b0; restartRx();
    cyc(2); agcLocked = 1'b1;
    cyc(2);
    check(ccaBusy, 1'b1, "R3 gain loss busy");
    curReq = "R4";
    cyc(36);   // past check of dwell 1 (invalid)
    check(ccaBusy, 1'b1, "R4 held after invalid check");
    cyc(40);   // past check of dwell 2 (valid, no peak)
    check(ccaBusy, 1'b0, "R4 cleared by empty check");

    // R6: gain loss then one valid peak, then R8 end of packet
    curReq = "R6";
    agcLocked = 1'b0; restartRx();
    cyc(3); agcLocked = 1'b1;
    cyc(42);   // into dwell 2
    pulseCorr();
    cyc(34);
    check(tracking, 1'b1, "R6 tracking after single hit");
    check(ccaBusy, 1'b1, "R6 busy while tracking");
    curReq = "R8";
    endOfPacket = 1'b1; cyc(1); endOfPacket = 1'b0;
    cyc(1);
    check(tracking, 1'b0, "R8 end of packet clears tracking");
    check(ccaBusy, 1'b0, "R8 end of packet clears busy");

    // R7: two consecutive hits without gain loss
    curReq = "R7";
    ccaMode = 3'd3; restartRx();
    cyc(5); pulseCorr();
    cyc(30);
    check(tracking, 1'b0, "R7 no tracking after one hit");
    check(ccaBusy, 1'b1, "R7 correlation flag busy");
    cyc(8); pulseCorr();
    cyc(39);
    check(tracking, 1'b1, "R7 tracking after two hits");

    // R7: hit, miss, hit must not enter tracking
    restartRx();
    cyc(5); pulseCorr();   // dwell 1 hit
    cyc(74);               // dwell 2 no hit
    pulseCorr();           // dwell 3 hit
    cyc(35);
    check(tracking, 1'b0, "R7 broken pair");
    cyc(5); pulseCorr();   // dwell 4 hit
    cyc(40);
    check(tracking, 1'b1, "R7 pair after break");

    // R5: peak after the check cycle does not count
    curReq = "R5";
    restartRx();
    cyc(36); pulseCorr();  // pos 36, after check at 34
    cyc(40);
    check(ccaBusy, 1'b0, "R5 late peak ignored");
    check(tracking, 1'b0, "R5 late peak no tracking");

    // R10: correlation flag held through an invalid check
    curReq = "R10";
    restartRx();
    cyc(5); pulseCorr();   // dwell 1 valid hit
    cyc(39);               // dwell 2 pos 5
    agcLocked = 1'b0; cyc(1); agcLocked = 1'b1;
    cyc(31);               // past dwell 2 check (invalid)
    check(ccaBusy, 1'b1, "R10 flag held across invalid check");
    check(tracking, 1'b0, "R10 invalid check no tracking");
    cyc(44);               // past dwell 3 check (valid, no peak)
    check(ccaBusy, 1'b0, "R10 flag cleared by valid miss");

    // R9: combined modes
    curReq = "R9";
    ccaMode = 3'd4; restartRx(); rssiLevel = 8'd150;
    cyc(4);
    check(ccaBusy, 1'b1, "R9 energy or sense");
    ccaMode = 3'd5; cyc(2);
    check(ccaBusy, 1'b0, "R9 energy and no sense");
    agcLocked = 1'b0; cyc(1); agcLocked = 1'b1; cyc(2);
    check(ccaBusy, 1'b1, "R9 energy and gain loss");
    rssiLevel = 8'd10; cyc(3);
    check(ccaBusy, 1'b0, "R9 sense without energy");

    // mixed random traffic against the model
    curReq = "R9";
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0) ccaMode = 3'($urandom_range(0, 7));
      rxEnable    = ($urandom_range(0, 299) != 0);
      endOfPacket = ($urandom_range(0, 399) == 0);
      agcLocked   = ($urandom_range(0, 59) != 0);
      corrHit     = ($urandom_range(0, 24) == 0);
      rssiLevel   = 8'($urandom_range(80, 120));
      cyc(1);
    end
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    #2000000;
    if (!fin) begin
      fin = 1;
      total++;
      bad++;
      $display("FAIL %s watchdog: actual=running expected=finished", curReq);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule